// File: doc/BRIEF.md
# Chained 64-bit Multiply-Accumulate Unit

This unit takes three 64-bit operands A, B and C and forms the full 128-bit value A times B plus C. It returns that value as two 64-bit words. The low word is the result. The high word is the carry, which the caller passes back in as C on the next operation of a big-integer chain. Because of this, a long unsigned number can be multiplied by one 64-bit scalar one word at a time, starting with C at zero. The unit does not read a register file or decode instructions.

A mode input selects one of two variants:
- Plain unsigned arithmetic.
- A mixed form, in which A is unsigned, B is a two's-complement value and C is sign-extended.

Internally the unit builds the product with an iterative shift-and-add datapath that retires `DIGIT_BITS` multiplier bits per cycle. It then applies the sign correction and adds the extended addend in a final cycle.

The handshake is start/busy/done and the outputs are registered. A controller state machine has three states:
- `S_IDLE` waits for `start_i`.
- `S_MUL` steps the shift-and-add loop.
- `S_FIX` applies the sign correction, adds C and loads the output registers.

The transitions are:
- *accept*: `S_IDLE` to `S_MUL`, when `start_i` is high.
- *last_digit*: `S_MUL` to `S_FIX`, when the iteration counter reaches its final value.
- *retire*: `S_FIX` to `S_IDLE`, unconditionally. This raises `done_o` for one cycle.

Top module: `chain_mac`

## Requirements
- R1: With `mode_i` = 0, {`carry_o`,`result_o`} equals the unsigned product A*B plus C zero-extended to 128 bits.
- R2: With `mode_i` = 1, {`carry_o`,`result_o`} equals, modulo 2^128, unsigned A times sign-extended B plus sign-extended C. When B is negative, the product is formed as the negation of A times the magnitude of B.
- R3: In unsigned mode with A, B and C all ones, the sum exactly fills 128 bits: `carry_o` is all ones and `result_o` is zero.
- R4: A `start_i` seen while idle raises `busy_o` on the next cycle. All operands and the mode are captured on that edge, so later changes on the operand inputs do not affect the result.
- R5: A `start_i` seen while `busy_o` is high is ignored. The running operation completes with its own operands and its normal latency, and no extra `done_o` follows.
- R6: `done_o` is a one-cycle pulse, and `busy_o` is low whenever `done_o` is high.
- R7: `result_o` and `carry_o` change only on the cycle in which `done_o` rises, and hold between operations.
- R8: `done_o` rises after the (OPW/DIGIT_BITS + 1)-th rising edge following the accepting edge. With the defaults, that is edge 65.
- R9: Feeding each carry back as the next C, with C = 0 for the first word, yields the exact unsigned product of a multi-word number and a 64-bit scalar.
- R10: After reset, `busy_o` and `done_o` are low and both data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new operation (taken only when idle) |
| mode_i | input | 1 | 0 = unsigned, 1 = unsigned A with signed B and C |
| a_i | input | 64 | Multiplicand A (always unsigned) |
| b_i | input | 64 | Multiplier B |
| c_i | input | 64 | Addend C, normally the previous carry |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the outputs are new |
| result_o | output | 64 | Low 64 bits of the sum |
| carry_o | output | 64 | High 64 bits of the sum |

## Verification
The embedded properties assume that reset is applied before the first operation. They also assume that `start_i` is a level sampled on rising edges, and they place no limit on operand values. The stimulus changes every input half a cycle away from the rising edge. It scrambles the operand pins right after acceptance, which exercises the capture rule. It also raises `start_i` in the middle of a computation, so that the ignore rule is exercised rather than assumed.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MUL  = 2'd1,
        S_FIX  = 2'd2
    } mac_state_e;

    typedef enum logic {
        MODE_UU = 1'b0,
        MODE_US = 1'b1
    } mac_mode_e;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
#(
    parameter int ITERS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic fin_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

    mac_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_i) state_d = S_MUL;
            S_MUL:  if (cnt_q == LAST) state_d = S_FIX;
            S_FIX:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= (state_q == S_FIX);
            if (state_q == S_MUL) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign load_o = (state_q == S_IDLE) && start_i;
    assign step_o = (state_q == S_MUL);
    assign fin_o  = (state_q == S_FIX);
    assign busy_o = (state_q != S_IDLE);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R4
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R5
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && start_i && !(cnt_q == LAST)) |=> step_o);
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
#(
    parameter int OPW        = 64,
    parameter int DIGIT_BITS = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic           fin_i,
    input  logic           mode_i,
    input  logic [OPW-1:0] a_i,
    input  logic [OPW-1:0] b_i,
    input  logic [OPW-1:0] c_i,
    output logic [OPW-1:0] result_o,
    output logic [OPW-1:0] carry_o
);
    localparam int DW = 2 * OPW;

    logic [DW-1:0]  acc_q, mcand_q, addend;
    logic [OPW-1:0] mplier_q, c_q;
    logic           neg_q;
    mac_mode_e      mode_q;
    logic [DW-1:0]  prod_fix, c_ext, sum;

    generate
        if (DIGIT_BITS == 2) begin : g_radix4
            always_comb begin
                unique case (mplier_q[1:0])
                    2'd0:    addend = '0;
                    2'd1:    addend = mcand_q;
                    2'd2:    addend = mcand_q << 1;
                    default: addend = mcand_q + (mcand_q << 1);
                endcase
            end
        end else begin : g_radix2
            assign addend = mplier_q[0] ? mcand_q : '0;
        end
    endgenerate

    always_comb begin
        prod_fix = neg_q ? (~acc_q + 1'b1) : acc_q;
        if (mode_q == MODE_US) begin
            c_ext = {{OPW{c_q[OPW-1]}}, c_q};
        end else begin
            c_ext = {{OPW{1'b0}}, c_q};
        end
        sum = prod_fix + c_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            c_q      <= '0;
            neg_q    <= 1'b0;
            mode_q   <= MODE_UU;
        end else if (load_i) begin
            acc_q    <= '0;
            mcand_q  <= {{OPW{1'b0}}, a_i};
            mode_q   <= mac_mode_e'(mode_i);
            c_q      <= c_i;
            neg_q    <= mode_i && b_i[OPW-1];
            mplier_q <= (mode_i && b_i[OPW-1]) ? (~b_i + 1'b1) : b_i;
        end else if (step_i) begin
            acc_q    <= acc_q + addend;
            mcand_q  <= mcand_q << DIGIT_BITS;
            mplier_q <= mplier_q >> DIGIT_BITS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            carry_o  <= '0;
        end else if (fin_i) begin
            result_o <= sum[OPW-1:0];
            carry_o  <= sum[DW-1:OPW];
        end
    end

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_i |=> ($stable(result_o) && $stable(carry_o)));

    // R2
    magnitude_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && mode_i && b_i[OPW-1]) |=> (neg_q && (mplier_q == (~$past(b_i) + 1'b1))));
endmodule

// File: rtl/chain_mac.sv
module chain_mac #(
    parameter int OPW        = 64,
    parameter int DIGIT_BITS = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           mode_i,
    input  logic [OPW-1:0] a_i,
    input  logic [OPW-1:0] b_i,
    input  logic [OPW-1:0] c_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [OPW-1:0] result_o,
    output logic [OPW-1:0] carry_o
);
    localparam int ITERS = OPW / DIGIT_BITS;

    logic load, step, fin;

    mac_ctrl #(.ITERS(ITERS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .fin_o   (fin),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    mac_datapath #(.OPW(OPW), .DIGIT_BITS(DIGIT_BITS)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .fin_i    (fin),
        .mode_i   (mode_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .c_i      (c_i),
        .result_o (result_o),
        .carry_o  (carry_o)
    );

    // R8
    fin_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done_o);
endmodule

// File: tb/sim_chain_mac.sv
module sim_chain_mac;
    localparam int OPW = 64;
    localparam int LAT = OPW + 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic           mode_i = 1'b0;
    logic [OPW-1:0] a_i = '0, b_i = '0, c_i = '0;
    logic           busy_o, done_o;
    logic [OPW-1:0] result_o, carry_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    chain_mac u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .a_i(a_i), .b_i(b_i), .c_i(c_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .carry_o(carry_o)
    );

    function automatic logic [127:0] ref_mac(logic [63:0] a, logic [63:0] b,
                                             logic [63:0] c, logic m);
        logic [127:0] bx, cx;
        bx = m ? {{64{b[63]}}, b} : {64'b0, b};
        cx = m ? {{64{c[63]}}, c} : {64'b0, c};
        return {64'b0, a} * bx + cx;
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Runs one operation; optionally pulses start again mid-computation.
    task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                          input logic [63:0] c, input logic m, input bit poke,
                          output logic [127:0] got, output int cyc);
        a_i = a; b_i = b; c_i = c; mode_i = m; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        a_i = rnd64(); b_i = rnd64(); c_i = rnd64(); mode_i = ~m;
        cyc = 1;
        while (!done_o && cyc < 1000) begin
            if (poke && cyc == 20) start_i = 1'b1;
            if (poke && cyc == 21) start_i = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        got = {carry_o, result_o};
        check(done_o == 1'b1, "R8", "done seen", {127'b0, done_o}, 128'd1);
        check(busy_o == 1'b0, "R6", "busy low at done", {127'b0, busy_o}, 128'd0);
        @(negedge clk);
        check(done_o == 1'b0, "R6", "done one cycle", {127'b0, done_o}, 128'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [127:0] got, exp;
        int cyc;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!busy_o && !done_o, "R10", "flags after reset",
              {126'b0, busy_o, done_o}, 128'd0);
        check({carry_o, result_o} == 128'd0, "R10", "data after reset",
              {carry_o, result_o}, 128'd0);

        // R3 all ones fill 128 bits exactly
        run_op('1, '1, '1, 1'b0, 1'b0, got, cyc);
        check(got == {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, "R3", "all ones",
              got, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0});
        check(cyc == LAT, "R8", "latency", 128'(cyc), 128'(LAT));

        // R1 directed
        run_op(64'd0, 64'd12345, 64'd77, 1'b0, 1'b0, got, cyc);
        check(got == 128'd77, "R1", "zero A", got, 128'd77);
        run_op(64'h8000_0000_0000_0000, 64'd2, 64'd1, 1'b0, 1'b0, got, cyc);
        exp = ref_mac(64'h8000_0000_0000_0000, 64'd2, 64'd1, 1'b0);
        check(got == exp, "R1", "carry out of low word", got, exp);

        // R2 directed: negative B and negative C
        run_op(64'd5, -64'sd3, -64'sd1, 1'b1, 1'b0, got, cyc);
        exp = -128'sd16;
        check(got == exp, "R2", "neg B neg C", got, exp);
        run_op('1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 1'b0, got, cyc);
        exp = ref_mac('1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1);
        check(got == exp, "R2", "most negative B and C", got, exp);
        run_op('1, '1, '1, 1'b1, 1'b0, got, cyc);
        exp = ref_mac('1, '1, '1, 1'b1);
        check(got == exp, "R2", "all ones mixed", got, exp);

        // R5 start while busy is ignored
        run_op(64'd1000, 64'd3000, 64'd7, 1'b0, 1'b1, got, cyc);
        check(got == 128'd3000007, "R5", "busy start ignored result", got, 128'd3000007);
        check(cyc == LAT, "R5", "busy start latency", 128'(cyc), 128'(LAT));
        begin
            bit extra = 1'b0;
            for (int i = 0; i < LAT + 4; i++) begin
                @(negedge clk);
                if (done_o || busy_o) extra = 1'b1;
            end
            check(!extra, "R5", "no extra operation", {127'b0, extra}, 128'd0);
        end

        // R7 outputs hold while idle with changing inputs
        a_i = rnd64(); b_i = rnd64(); c_i = rnd64();
        repeat (5) @(negedge clk);
        check({carry_o, result_o} == 128'd3000007, "R7", "hold while idle",
              {carry_o, result_o}, 128'd3000007);

        // R1/R2/R4 random, with operand pins scrambled after accept
        for (int i = 0; i < 60; i++) begin
            logic [63:0] a, b, c;
            logic m;
            a = rnd64(); b = rnd64(); c = rnd64(); m = i[0];
            run_op(a, b, c, m, 1'b0, got, cyc);
            exp = ref_mac(a, b, c, m);
            check(got == exp, m ? "R2" : "R1", "random R4 capture", got, exp);
        end

        // R9 chain: 4-word number times scalar
        for (int t = 0; t < 3; t++) begin
            logic [63:0]  v [4];
            logic [63:0]  r [4];
            logic [63:0]  s, cy;
            logic [255:0] vb;
            logic [319:0] pe, pg;
            s = (t == 0) ? '1 : rnd64();
            for (int k = 0; k < 4; k++) v[k] = (t == 0) ? '1 : rnd64();
            cy = '0;
            for (int k = 0; k < 4; k++) begin
                run_op(v[k], s, cy, 1'b0, 1'b0, got, cyc);
                r[k] = got[63:0];
                cy = got[127:64];
            end
            vb = {v[3], v[2], v[1], v[0]};
            pe = {64'b0, vb} * {256'b0, s};
            pg = {cy, r[3], r[2], r[1], r[0]};
            check(pg == pe, "R9", "chain product", pg[127:0], pe[127:0]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule